// File: doc/BRIEF.md
# Relocatable Interrupt Vector Generator

This block produces the program-space address that the program counter takes when the core accepts a reset, an interrupt or a trap. Vectors are soft: the address handed out is where execution continues, and each vector owns a slot of four consecutive words. That is room for a two-word delayed branch or for two one-word instructions. The 32 slots together fill one 128-word page.

The page is chosen by a 9-bit page pointer. This pointer is the top field, bits 15:7, of a 16-bit processor mode register that software can write. Every bit of that register is stored and reads back as written. Hardware reset loads the pointer with all ones, so the table starts at FF80h. Software can later move the table to the start of any 128-word page by rewriting the field. A request that is marked as the reset vector always resolves to FF80h, so the reset entry point cannot be moved.

The interrupt or trap logic raises a request strobe together with a vector number. The address is driven combinationally in that same cycle, and a one-cycle acknowledge marks a newly raised request.

Top module: `ivg_vector_gen`

## Requirements
- R1: While and after hardware reset (`rst_n` low), the mode register reads FF80h: the pointer field is all ones and bits 6:0 are zero.
- R2: For a non-reset request, `vec_addr` equals {mode bits 15:7, `vec_num`[4:0], 2'b00} in the same cycle as `vec_req`.
- R3: When `mode_wr_en` is high at a clock edge, all 16 bits of `mode_wr_data` are stored, and `mode_rd_data` returns them exactly after that edge.
- R4: If a request and a mode write fall in the same cycle, the address is formed from the pointer value held before the write.
- R5: A request with `vec_is_reset` high outputs FF80h, whatever the pointer value and whatever `vec_num` holds.
- R6: `vec_ack` is high only in the first cycle of a request. It goes low in the next cycle even if `vec_req` stays high.
- R7: When `vec_req` is low, `vec_addr` is 0000h and `vec_ack` is low.
- R8: Without a write, the mode register keeps its value, and vector requests do not change it.
- R9: A hardware reset after the table has been relocated puts the pointer back to all ones, so user vectors are again fetched from page FF80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mode_wr_en | input | 1 | Write strobe for the mode register |
| mode_wr_data | input | 16 | Value written to the mode register |
| mode_rd_data | output | 16 | Current mode register contents |
| vec_req | input | 1 | Vector request strobe |
| vec_is_reset | input | 1 | Marks the request as the reset vector |
| vec_num | input | 5 | Vector number, 0 to 31 |
| vec_addr | output | 16 | Vector fetch address, 0000h when idle |
| vec_ack | output | 1 | One-cycle acknowledge of a new request |

## Verification
A pointer rewrite and a vector request can land in the same cycle. The bench provokes this by driving a mode write and a rising request on one clock. It then judges the result in three ways:
- the address seen before the edge must carry the old page;
- the readback after the edge must show the new value;
- the address on the following cycle, with the request still held, must move to the new page while the acknowledge stays low.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

   // Kind of request presented to the address former
   typedef enum logic [1:0] {
      IVG_IDLE  = 2'd0,
      IVG_USER  = 2'd1,
      IVG_RESET = 2'd2
   } ivg_kind_e;

   function automatic ivg_kind_e ivg_classify(input logic req, input logic is_reset);
      if (!req)          return IVG_IDLE;
      else if (is_reset) return IVG_RESET;
      else               return IVG_USER;
   endfunction

endpackage

// File: rtl/ivg_mode_reg.sv
module ivg_mode_reg #(
   parameter int MODE_W   = 16,
   parameter int PAGE_W   = 9,
   parameter int RST_LOW  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   output logic [MODE_W-1:0] rd_data,
   output logic [PAGE_W-1:0] page_ptr
);
   localparam int LOW_W = MODE_W - PAGE_W;
   localparam logic [LOW_W-1:0] LOW_RST = LOW_W'(RST_LOW);

   logic [PAGE_W-1:0] ptr_q;
   logic [LOW_W-1:0]  low_q;

   // Pointer field: hardware reset forces all ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '1;
      else if (wr_en) ptr_q <= wr_data[MODE_W-1 -: PAGE_W];
   end

   // Remaining mode bits are kept verbatim
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_q <= LOW_RST;
      else if (wr_en) low_q <= wr_data[LOW_W-1:0];
   end

   assign rd_data  = {ptr_q, low_q};
   assign page_ptr = ptr_q;
endmodule

// File: rtl/ivg_addr_calc.sv
module ivg_addr_calc
   import ivg_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int PAGE_W          = 9,
   parameter int VEC_W           = 5,
   parameter int SLOT_LSB        = 2,
   parameter bit LOCK_RESET_PAGE = 1'b1
) (
   input  ivg_kind_e         kind,
   input  logic [PAGE_W-1:0] page_ptr,
   input  logic [VEC_W-1:0]  num,
   output logic [ADDR_W-1:0] addr
);
   localparam int OFS_W = VEC_W + SLOT_LSB;

   logic [PAGE_W-1:0] reset_page;

   generate
      if (LOCK_RESET_PAGE) begin : g_locked
         // Reset entry point is pinned to the top page
         assign reset_page = '1;
      end else begin : g_follow
         assign reset_page = page_ptr;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         IVG_USER:  addr = {page_ptr, num, {SLOT_LSB{1'b0}}};
         IVG_RESET: addr = {reset_page, {OFS_W{1'b0}}};
         default:   addr = '0;
      endcase
   end
endmodule

// File: rtl/ivg_ack_gen.sv
module ivg_ack_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ack
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req;
   end

   // Acknowledge only the first cycle of a request
   assign ack = req & ~req_q;
endmodule

// File: rtl/ivg_vector_gen.sv
module ivg_vector_gen
   import ivg_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int NUM_VEC         = 32,
   parameter int SLOT_WORDS      = 4,
   parameter int MODE_W          = 16,
   parameter int MODE_RST_LOW    = 0,
   parameter bit LOCK_RESET_PAGE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_wr_en,
   input  logic [MODE_W-1:0]          mode_wr_data,
   output logic [MODE_W-1:0]          mode_rd_data,
   input  logic                       vec_req,
   input  logic                       vec_is_reset,
   input  logic [$clog2(NUM_VEC)-1:0] vec_num,
   output logic [ADDR_W-1:0]          vec_addr,
   output logic                       vec_ack
);
   localparam int VEC_W    = $clog2(NUM_VEC);
   localparam int SLOT_LSB = $clog2(SLOT_WORDS);
   localparam int PAGE_W   = ADDR_W - VEC_W - SLOT_LSB;

   // Elaboration-time parameter checks
   generate
      if ((1 << VEC_W) != NUM_VEC) begin : g_bad_num
         initial $fatal(1, "NUM_VEC must be a power of two");
      end
      if ((1 << SLOT_LSB) != SLOT_WORDS) begin : g_bad_slot
         initial $fatal(1, "SLOT_WORDS must be a power of two");
      end
      if (PAGE_W < 1) begin : g_bad_page
         initial $fatal(1, "vector table does not fit the address width");
      end
      if (MODE_W <= PAGE_W) begin : g_bad_mode
         initial $fatal(1, "mode register must be wider than the pointer");
      end
   endgenerate

   logic [PAGE_W-1:0] page_ptr;
   ivg_kind_e         kind;

   ivg_mode_reg #(
      .MODE_W  (MODE_W),
      .PAGE_W  (PAGE_W),
      .RST_LOW (MODE_RST_LOW)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mode_wr_en),
      .wr_data  (mode_wr_data),
      .rd_data  (mode_rd_data),
      .page_ptr (page_ptr)
   );

   assign kind = ivg_classify(vec_req, vec_is_reset);

   ivg_addr_calc #(
      .ADDR_W          (ADDR_W),
      .PAGE_W          (PAGE_W),
      .VEC_W           (VEC_W),
      .SLOT_LSB        (SLOT_LSB),
      .LOCK_RESET_PAGE (LOCK_RESET_PAGE)
   ) u_calc (
      .kind     (kind),
      .page_ptr (page_ptr),
      .num      (vec_num),
      .addr     (vec_addr)
   );

   ivg_ack_gen u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (vec_req),
      .ack   (vec_ack)
   );
endmodule

// File: rtl/ivg_vector_gen_chk.sv
module ivg_vector_gen_chk #(
   parameter int ADDR_W          = 16,
   parameter int NUM_VEC         = 32,
   parameter int SLOT_WORDS      = 4,
   parameter int MODE_W          = 16,
   parameter bit LOCK_RESET_PAGE = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_wr_en,
   input logic [MODE_W-1:0]          mode_wr_data,
   input logic [MODE_W-1:0]          mode_rd_data,
   input logic                       vec_req,
   input logic                       vec_is_reset,
   input logic [$clog2(NUM_VEC)-1:0] vec_num,
   input logic [ADDR_W-1:0]          vec_addr,
   input logic                       vec_ack
);
   localparam int VEC_W    = $clog2(NUM_VEC);
   localparam int SLOT_LSB = $clog2(SLOT_WORDS);
   localparam int PAGE_W   = ADDR_W - VEC_W - SLOT_LSB;
   localparam logic [ADDR_W-1:0] TOP_ADDR = {{PAGE_W{1'b1}}, {(ADDR_W-PAGE_W){1'b0}}};

   // R2
   user_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && !vec_is_reset) |->
      (vec_addr == {mode_rd_data[MODE_W-1 -: PAGE_W], vec_num, {SLOT_LSB{1'b0}}}));

   // R3
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_en |=> (mode_rd_data == $past(mode_wr_data)));

   // R8
   hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr_en |=> $stable(mode_rd_data));

   generate
      if (LOCK_RESET_PAGE) begin : g_lock_chk
         // R5
         reset_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_req && vec_is_reset) |-> (vec_addr == TOP_ADDR));
      end
   endgenerate

   // R6
   ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ack |-> vec_req);

   // R6
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ack |=> !vec_ack);

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |-> (vec_addr == '0));
endmodule

bind ivg_vector_gen ivg_vector_gen_chk #(
   .ADDR_W          (ADDR_W),
   .NUM_VEC         (NUM_VEC),
   .SLOT_WORDS      (SLOT_WORDS),
   .MODE_W          (MODE_W),
   .LOCK_RESET_PAGE (LOCK_RESET_PAGE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_wr_en   (mode_wr_en),
   .mode_wr_data (mode_wr_data),
   .mode_rd_data (mode_rd_data),
   .vec_req      (vec_req),
   .vec_is_reset (vec_is_reset),
   .vec_num      (vec_num),
   .vec_addr     (vec_addr),
   .vec_ack      (vec_ack)
);

// File: tb/ivg_vector_gen_tb.sv
module ivg_vector_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr_en = 1'b0;
   logic [15:0] mode_wr_data = '0;
   logic [15:0] mode_rd_data;
   logic        vec_req = 1'b0;
   logic        vec_is_reset = 1'b0;
   logic [4:0]  vec_num = '0;
   logic [15:0] vec_addr;
   logic        vec_ack;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   ivg_vector_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_wr_en   (mode_wr_en),
      .mode_wr_data (mode_wr_data),
      .mode_rd_data (mode_rd_data),
      .vec_req      (vec_req),
      .vec_is_reset (vec_is_reset),
      .vec_num      (vec_num),
      .vec_addr     (vec_addr),
      .vec_ack      (vec_ack)
   );

   // Entry: wr_en, wr_data, req, is_reset, num, exp_addr, exp_ack, exp_rd_after_edge
   localparam int NV = 15;
   localparam logic [56:0] TBL [NV] = '{
      {1'b0, 16'h0000, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'hFF80}, // idle (R7, R8)
      {1'b0, 16'h0000, 1'b1, 1'b0, 5'd3,  16'hFF8C, 1'b1, 16'hFF80}, // user vec 3 (R2, R6)
      {1'b0, 16'h0000, 1'b1, 1'b0, 5'd3,  16'hFF8C, 1'b0, 16'hFF80}, // held, no ack (R6)
      {1'b0, 16'h0000, 1'b0, 1'b0, 5'd9,  16'h0000, 1'b0, 16'hFF80}, // idle (R7)
      {1'b1, 16'h1234, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'h1234}, // relocate (R3)
      {1'b0, 16'h0000, 1'b1, 1'b0, 5'd31, 16'h127C, 1'b1, 16'h1234}, // new page, top slot (R2, R8)
      {1'b0, 16'h0000, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'h1234},
      {1'b1, 16'h8000, 1'b1, 1'b0, 5'd1,  16'h1204, 1'b1, 16'h8000}, // write + request (R4)
      {1'b0, 16'h0000, 1'b1, 1'b0, 5'd1,  16'h8004, 1'b0, 16'h8000}, // held, new page (R4, R6)
      {1'b0, 16'h0000, 1'b1, 1'b1, 5'd5,  16'hFF80, 1'b0, 16'h8000}, // reset kind (R5)
      {1'b0, 16'h0000, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'h8000},
      {1'b0, 16'h0000, 1'b1, 1'b1, 5'd17, 16'hFF80, 1'b1, 16'h8000}, // reset kind, odd num (R5)
      {1'b1, 16'h007F, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'h007F}, // low bits kept (R3)
      {1'b0, 16'h0000, 1'b1, 1'b0, 5'd2,  16'h0008, 1'b1, 16'h007F}, // page zero (R2)
      {1'b0, 16'h0000, 1'b0, 1'b0, 5'd0,  16'h0000, 1'b0, 16'h007F}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #40000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, held in reset
      repeat (3) @(posedge clk);
      #1 check("R1 rd in reset", mode_rd_data, 16'hFF80);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R1 rd after reset", mode_rd_data, 16'hFF80);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mode_wr_en   = TBL[i][56];
         mode_wr_data = TBL[i][55:40];
         vec_req      = TBL[i][39];
         vec_is_reset = TBL[i][38];
         vec_num      = TBL[i][37:33];
         #1;
         check($sformatf("R2/R4/R5/R7 addr row %0d", i), vec_addr, TBL[i][32:17]);
         check($sformatf("R6 ack row %0d", i), {15'd0, vec_ack}, {15'd0, TBL[i][16]});
         @(posedge clk);
         #1 check($sformatf("R3/R8 rd row %0d", i), mode_rd_data, TBL[i][15:0]);
      end

      // R9: relocate, then hardware reset restores the top page
      @(negedge clk);
      mode_wr_en = 1'b1; mode_wr_data = 16'h4015;
      vec_req = 1'b0; vec_is_reset = 1'b0;
      @(negedge clk);
      mode_wr_en = 1'b0;
      check("R3 rd before reset", mode_rd_data, 16'h4015);
      rst_n = 1'b0;
      #1 check("R9 rd in reset", mode_rd_data, 16'hFF80);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      vec_req = 1'b1; vec_num = 5'd2;
      #1 check("R9 user vec after reset", vec_addr, 16'hFF88);
      check("R9 ack after reset", {15'd0, vec_ack}, 16'd1);

      // R5: reset kind ignores a relocated pointer, addr checked at port
      @(negedge clk);
      vec_req = 1'b0; mode_wr_en = 1'b1; mode_wr_data = 16'h0A00;
      @(negedge clk);
      mode_wr_en = 1'b0;
      vec_req = 1'b1; vec_is_reset = 1'b1; vec_num = 5'd31;
      #1 check("R5 reset vec on relocated page", vec_addr, 16'hFF80);
      @(negedge clk);
      vec_req = 1'b0; vec_is_reset = 1'b0;
      #1 check("R8 rd after reset-kind request", mode_rd_data, 16'h0A00);
      check("R7 idle addr", vec_addr, 16'h0000);

      finish_run();
   end
endmodule